// File: doc/BRIEF.md
# Nibble Arithmetic-Logic Core

This block is a purely combinational 4-bit arithmetic and logic core. It takes two operands, a carry input and four separate function-select lines. It returns a 4-bit result and a carry output. One select line adds the operands together with the incoming carry. The other three produce the bitwise AND, exclusive-OR or inclusive-OR of the operands.

Inside the block, a chain of full adders produces the sum, and a set of bitwise gates produces the three logic results. A result steering stage passes the chosen value to the output. The carry output shows the adder's final carry only while addition is selected; it is held low for every other choice. The block has no clock and no storage, so the outputs follow the inputs within the same evaluation.

The function selects are meant to be one-hot or all low. If more than one line is driven anyway, a fixed order (add, then XOR, then OR, then AND) decides the output, so the result stays deterministic. A simulation check flags that case as a usage error. Bit 0 is the least significant bit on every bus.

Top module: `nib_alu_core`

## Requirements
- R1: With only `fn_sum_i` high, `res_o` equals the low 4 bits of `a_i + b_i + carry_i`.
- R2: With only `fn_sum_i` high, `carry_o` equals bit 4 of `a_i + b_i + carry_i`, which is the carry out of the most significant adder stage.
- R3: With only `fn_and_i` high, `res_o` equals `a_i & b_i`.
- R4: With only `fn_xor_i` high, `res_o` equals `a_i ^ b_i`.
- R5: With only `fn_or_i` high, `res_o` equals `a_i | b_i`.
- R6: Whenever `fn_sum_i` is low, `carry_o` is 0.
- R7: With all four select lines low, `res_o` is 4'b0000 and `carry_o` is 0.
- R8: For the AND, XOR and OR functions, the value of `carry_i` has no effect on `res_o` or `carry_o`.
- R9: The outputs follow any input change without a clock edge, since the block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand, bit 0 least significant |
| b_i | input | 4 | Second operand, bit 0 least significant |
| carry_i | input | 1 | Carry into the least significant adder stage |
| fn_sum_i | input | 1 | Select addition with carry |
| fn_and_i | input | 1 | Select bitwise AND |
| fn_xor_i | input | 1 | Select bitwise exclusive-OR |
| fn_or_i | input | 1 | Select bitwise inclusive-OR |
| res_o | output | 4 | Result of the selected function |
| carry_o | output | 1 | Adder carry out while addition is selected, otherwise 0 |

## Verification
The hardest behaviour to reach is a carry that travels the full length of the adder chain. This happens when every stage propagates, for example with operands 4'b1111 and 4'b0000 and the carry input high. Only then does a single input bit decide both the whole result and the carry output. The stimulus reaches this case, and every other case, by sweeping every operand pair, both carry values and all five legal select patterns. Directed cases at the all-ones and all-zeros corners and a seeded random phase follow the sweep. Some random vectors change only the carry input under a logic function, which shows that the carry input is ignored there.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

  // Default operand width of the core.
  localparam int unsigned NIB_W = 4;

  // Function select lines gathered for internal routing.
  typedef struct packed {
    logic sum;
    logic bxor;
    logic bor;
    logic band;
  } fn_sel_t;

endpackage

// File: rtl/nib_full_adder.sv
module nib_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic half_s;

  assign half_s = x_i ^ y_i;
  assign s_o    = half_s ^ c_i;
  assign c_o    = (x_i & y_i) | (half_s & c_i);

endmodule

// File: rtl/nib_ripple_adder.sv
module nib_ripple_adder #(
  parameter int unsigned WIDTH = nib_alu_pkg::NIB_W
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_o
);

  // chain[k] is the carry into stage k; chain[WIDTH] is the final carry.
  logic [WIDTH:0] chain;

  assign chain[0] = c_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    nib_full_adder u_fa (
      .x_i (x_i[k]),
      .y_i (y_i[k]),
      .c_i (chain[k]),
      .s_o (s_o[k]),
      .c_o (chain[k+1])
    );
  end

  assign c_o = chain[WIDTH];

endmodule

// File: rtl/nib_logic_unit.sv
module nib_logic_unit #(
  parameter int unsigned WIDTH = nib_alu_pkg::NIB_W
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] xor_o,
  output logic [WIDTH-1:0] or_o
);

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign and_o[k] = x_i[k] & y_i[k];
    assign xor_o[k] = x_i[k] ^ y_i[k];
    assign or_o[k]  = x_i[k] | y_i[k];
  end

endmodule

// File: rtl/nib_result_mux.sv
module nib_result_mux
  import nib_alu_pkg::*;
#(
  parameter int unsigned WIDTH = NIB_W
) (
  input  fn_sel_t          sel_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             sum_c_i,
  input  logic [WIDTH-1:0] and_i,
  input  logic [WIDTH-1:0] xor_i,
  input  logic [WIDTH-1:0] or_i,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o
);

  // Fixed order when more than one line is high: sum, xor, or, and.
  always_comb begin
    if (sel_i.sum) begin
      res_o = sum_i;
    end else if (sel_i.bxor) begin
      res_o = xor_i;
    end else if (sel_i.bor) begin
      res_o = or_i;
    end else if (sel_i.band) begin
      res_o = and_i;
    end else begin
      res_o = '0;
    end
  end

  // The carry leaves the core only while addition is chosen.
  assign c_o = sel_i.sum & sum_c_i;

endmodule

// File: rtl/nib_alu_core.sv
module nib_alu_core
  import nib_alu_pkg::*;
#(
  parameter int unsigned WIDTH = NIB_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  input  logic             fn_sum_i,
  input  logic             fn_and_i,
  input  logic             fn_xor_i,
  input  logic             fn_or_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);

  fn_sel_t          sel;
  logic [WIDTH-1:0] add_res;
  logic             add_c;
  logic [WIDTH-1:0] and_res;
  logic [WIDTH-1:0] xor_res;
  logic [WIDTH-1:0] or_res;

  assign sel.sum  = fn_sum_i;
  assign sel.bxor = fn_xor_i;
  assign sel.bor  = fn_or_i;
  assign sel.band = fn_and_i;

  nib_ripple_adder #(.WIDTH(WIDTH)) u_add (
    .x_i (a_i),
    .y_i (b_i),
    .c_i (carry_i),
    .s_o (add_res),
    .c_o (add_c)
  );

  nib_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .x_i   (a_i),
    .y_i   (b_i),
    .and_o (and_res),
    .xor_o (xor_res),
    .or_o  (or_res)
  );

  nib_result_mux #(.WIDTH(WIDTH)) u_mux (
    .sel_i   (sel),
    .sum_i   (add_res),
    .sum_c_i (add_c),
    .and_i   (and_res),
    .xor_i   (xor_res),
    .or_i    (or_res),
    .res_o   (res_o),
    .c_o     (carry_o)
  );

endmodule

// File: rtl/nib_alu_core_chk.sv
module nib_alu_core_chk #(
  parameter int unsigned WIDTH = nib_alu_pkg::NIB_W
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             carry_i,
  input logic             fn_sum_i,
  input logic             fn_and_i,
  input logic             fn_xor_i,
  input logic             fn_or_i,
  input logic [WIDTH-1:0] res_o,
  input logic             carry_o
);

  logic [3:0]     sel_vec;
  logic [WIDTH:0] ref_sum;

  assign sel_vec = {fn_sum_i, fn_and_i, fn_xor_i, fn_or_i};
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};

  always_comb begin
    // Usage check: the select lines must be one-hot or idle.
    a_sel_onehot: assert ($onehot0(sel_vec))
      else $error("select lines not one-hot: %b", sel_vec);

    // R1 and R2: the adder path with its carry.
    if (sel_vec == 4'b1000) begin
      a_r1_sum_value: assert ({carry_o, res_o} == ref_sum)
        else $error("sum path mismatch");
    end

    // R3: bitwise AND.
    if (sel_vec == 4'b0100) begin
      a_r3_and_value: assert (res_o == (a_i & b_i))
        else $error("and path mismatch");
    end

    // R6: the carry is gated off without addition.
    if (!fn_sum_i) begin
      a_r6_carry_gated: assert (carry_o == 1'b0)
        else $error("carry leaked without sum select");
    end

    // R7: idle selects give an all-zero output.
    if (sel_vec == 4'b0000) begin
      a_r7_idle_zero: assert (res_o == '0)
        else $error("idle result not zero");
    end
  end

endmodule

bind nib_alu_core nib_alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .carry_i  (carry_i),
  .fn_sum_i (fn_sum_i),
  .fn_and_i (fn_and_i),
  .fn_xor_i (fn_xor_i),
  .fn_or_i  (fn_or_i),
  .res_o    (res_o),
  .carry_o  (carry_o)
);

// File: tb/nib_alu_core_tb.sv
`timescale 1ns/1ps
module nib_alu_core_tb;

  logic       clk = 1'b0;
  logic [3:0] a, b;
  logic       cin;
  logic       s_sum, s_and, s_xor, s_or;
  logic [3:0] res;
  logic       cout;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  nib_alu_core u_dut (
    .a_i      (a),
    .b_i      (b),
    .carry_i  (cin),
    .fn_sum_i (s_sum),
    .fn_and_i (s_and),
    .fn_xor_i (s_xor),
    .fn_or_i  (s_or),
    .res_o    (res),
    .carry_o  (cout)
  );

  // Function codes used by the bench: 0 sum, 1 and, 2 xor, 3 or, 4 idle.
  function automatic logic [4:0] model(input logic [3:0] x, input logic [3:0] y,
                                       input logic c, input int f);
    logic [4:0] r;
    case (f)
      0: r = {1'b0, x} + {1'b0, y} + {4'b0, c};
      1: r = {1'b0, x & y};
      2: r = {1'b0, x ^ y};
      3: r = {1'b0, x | y};
      default: r = 5'b0;
    endcase
    return r;
  endfunction

  function automatic string req_of(input int f);
    case (f)
      0: return "R1/R2 sum";
      1: return "R3/R6/R8 and";
      2: return "R4/R6/R8 xor";
      3: return "R5/R6/R8 or";
      default: return "R7 idle";
    endcase
  endfunction

  task automatic apply(input logic [3:0] x, input logic [3:0] y,
                       input logic c, input int f);
    @(negedge clk);
    a = x; b = y; cin = c;
    s_sum = (f == 0); s_and = (f == 1); s_xor = (f == 2); s_or = (f == 3);
  endtask

  task automatic check(input string tag, input logic [4:0] exp);
    n_checks++;
    if ({cout, res} !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%b: actual=%b expected=%b",
               tag, a, b, cin, {cout, res}, exp);
    end
  endtask

  task automatic run_vec(input logic [3:0] x, input logic [3:0] y,
                         input logic c, input int f);
    apply(x, y, c, f);
    #1;
    check(req_of(f), model(x, y, c, f));
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    s_sum = 1'b0; s_and = 1'b0; s_xor = 1'b0; s_or = 1'b0;
    #1;
    check("R7 initial idle", 5'b0);

    // Exhaustive sweep across operands, carry and the five legal selects.
    for (int f = 0; f < 5; f++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++)
            run_vec(4'(x), 4'(y), 1'(c), f);

    // Directed corners: full carry propagation and overflow (R1, R2).
    run_vec(4'hF, 4'h0, 1'b1, 0);
    check("R2 full ripple", 5'b10000);
    run_vec(4'hF, 4'hF, 1'b1, 0);
    check("R2 max sum", 5'b11111);
    run_vec(4'h0, 4'h0, 1'b0, 0);
    check("R1 zero sum", 5'b00000);
    // Carry must stay low with all-ones logic inputs (R6).
    run_vec(4'hF, 4'hF, 1'b1, 3);
    check("R6 or carry low", 5'b01111);
    run_vec(4'hF, 4'hF, 1'b1, 4);
    check("R7 idle all ones", 5'b00000);

    // R9: change only an operand, sample before any clock edge.
    apply(4'h3, 4'h4, 1'b0, 0);
    #0.5;
    a = 4'h9;
    #0.5;
    check("R9 follows input", 5'b01101);

    // Seeded random phase; toggle carry alone under logic ops (R8).
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 600; i++) begin
      logic [3:0] rx, ry;
      logic       rc;
      int         rf;
      rx = 4'($urandom_range(15));
      ry = 4'($urandom_range(15));
      rc = 1'($urandom_range(1));
      rf = int'($urandom_range(4));
      run_vec(rx, ry, rc, rf);
      if (rf != 0) begin
        #0.5;
        cin = ~rc;
        #0.5;
        check("R8 carry ignored", model(rx, ry, rc, rf));
      end
    end

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule